// File: doc/BRIEF.md
# Eight-Pin Port Cell With Edge Interrupts

This block is the control cell for an eight-pin general purpose port. Each pin carries five configuration bits: direction, output level, pull enable, polarity and interrupt enable. From these the cell drives the pad output value and output enable, and the pull-up and pull-down controls. It also watches the resolved digital pad level for a chosen edge. A single polarity bit per pin does two jobs. It chooses the pull direction, with 0 for up and 1 for down. It also chooses the interrupt edge, with 0 for falling and 1 for rising.

The pad level is brought into the clock domain through a two-flop synchronizer. An edge is found by comparing the newest synchronized sample with the one before it. A qualifying edge sets a sticky per-pin flag, and software clears a flag by writing 1 to its bit. The port interrupt request is the OR across pins of flag AND enable. Edges are still seen while a pin drives its own pad, so a pin in output mode can flag its own transitions. Pulls, however, are always off in output mode.

Software reaches the configuration through a plain register port. It has a write strobe, a three-bit address and a pin-wide data word, and reads are combinational. None of these pins carry a data stream, so they use no valid/ready handshake and have no back-pressure.

Top module: `gpio_port8`

## Requirements
- R1: After reset every configuration register and every flag reads 0. `pad_oe_o`, `pull_up_o`, `pull_dn_o` and `irq_o` are all 0.
- R2: `pad_oe_o[i]` equals the direction bit of pin i, where 1 means output. `pad_out_o[i]` equals the output-level bit of pin i.
- R3: For an input pin with pull enable 1, polarity 0 drives `pull_up_o[i]` and polarity 1 drives `pull_dn_o[i]`. With pull enable 0 neither pull control is driven.
- R4: For an output pin both pull controls are 0, whatever the pull-enable bit holds.
- R5: With polarity 0 a falling pad edge sets flag i. With polarity 1 a rising edge sets it. The opposite edge leaves the flag alone. The flag reads 1 after the third rising clock edge that follows the pad change, and not after the second.
- R6: While the interrupt-enable bit of a pin is 0, no edge on that pin sets its flag.
- R7: For a pin in output mode with interrupt enable 1, the selected edge of its own driven level sets its flag.
- R8: Writing the flag register clears each flag whose data bit is 1 and keeps each flag whose data bit is 0. When a clear and a set reach the same flag in the same cycle, the flag ends up 1.
- R9: `irq_o` is 1 exactly when some pin has both its flag and its interrupt enable at 1. Clearing the enables drops `irq_o` and leaves the flags in place.
- R10: The register addresses are: 0 direction, 1 output level, 2 pull enable, 3 polarity, 4 interrupt enable, 5 flags (write 1 to clear), 6 synchronized pad level (read only). Address 7 reads 0. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational read data for `reg_addr_i` |
| pad_in_i | input | 8 | Resolved digital pad levels |
| pad_out_o | output | 8 | Level driven onto each pad |
| pad_oe_o | output | 8 | Output enable for each pad |
| pull_up_o | output | 8 | Pull-up enable for each pad |
| pull_dn_o | output | 8 | Pull-down enable for each pad |
| irq_o | output | 1 | Port interrupt request |

## Verification
Pull control is tried with pull enable on and off, with mixed polarities across pins, and again with every pin set as output. These cases separate the up/down choice from the output-mode override. Edge detection is tried with rising and falling steps on pins whose polarity matches the step and on pins whose polarity does not, on a pin with its enable cleared, and on a pin that toggles its own driven level. This shows which edge each polarity accepts and that the enable and the direction act independently. The flag path is tried with a partial write-1-to-clear, a clear that lands in the same cycle as a new edge, and a drop of the enables while flags are pending. These cases separate the clear priority from the gating of the request.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR    = 3'd0,
    SEL_LEVEL  = 3'd1,
    SEL_PULLEN = 3'd2,
    SEL_POL    = 3'd3,
    SEL_IEN    = 3'd4,
    SEL_FLAG   = 3'd5,
    SEL_PAD    = 3'd6,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  // per-pin configuration bundle handed from the register file to a slice
  typedef struct packed {
    logic dir;
    logic lvl;
    logic pen;
    logic pol;
    logic ien;
  } pin_cfg_t;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [NPINS-1:0]      wdata_i,
  output logic [NPINS-1:0]      rdata_o,
  input  logic [NPINS-1:0]      flag_i,
  input  logic [NPINS-1:0]      pad_lvl_i,
  output pin_cfg_t [NPINS-1:0]  cfg_o,
  output logic [NPINS-1:0]      clr_o
);
  logic [NPINS-1:0] dir_q, lvl_q, pen_q, pol_q, ien_q;

  logic hit_dir, hit_lvl, hit_pen, hit_pol, hit_ien, hit_flag;

  always_comb begin
    hit_dir  = we_i && (addr_i == SEL_DIR);
    hit_lvl  = we_i && (addr_i == SEL_LEVEL);
    hit_pen  = we_i && (addr_i == SEL_PULLEN);
    hit_pol  = we_i && (addr_i == SEL_POL);
    hit_ien  = we_i && (addr_i == SEL_IEN);
    hit_flag = we_i && (addr_i == SEL_FLAG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
      pen_q <= '0;
      pol_q <= '0;
      ien_q <= '0;
    end else begin
      if (hit_dir) dir_q <= wdata_i;
      if (hit_lvl) lvl_q <= wdata_i;
      if (hit_pen) pen_q <= wdata_i;
      if (hit_pol) pol_q <= wdata_i;
      if (hit_ien) ien_q <= wdata_i;
    end
  end

  // write-1-to-clear request, one cycle wide, consumed by the slices
  assign clr_o = hit_flag ? wdata_i : '0;

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_cfg
      assign cfg_o[p].dir = dir_q[p];
      assign cfg_o[p].lvl = lvl_q[p];
      assign cfg_o[p].pen = pen_q[p];
      assign cfg_o[p].pol = pol_q[p];
      assign cfg_o[p].ien = ien_q[p];
    end
  endgenerate

  always_comb begin
    unique case (addr_i)
      SEL_DIR:    rdata_o = dir_q;
      SEL_LEVEL:  rdata_o = lvl_q;
      SEL_PULLEN: rdata_o = pen_q;
      SEL_POL:    rdata_o = pol_q;
      SEL_IEN:    rdata_o = ien_q;
      SEL_FLAG:   rdata_o = flag_i;
      SEL_PAD:    rdata_o = pad_lvl_i;
      default:    rdata_o = '0;
    endcase
  end

  // R2 / R10: a direction write lands in the register on the next edge
  a_r10_dir_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dir |=> (dir_q == $past(wdata_i)));

  // R10: writes to the read-only and unused addresses leave configuration alone
  a_r10_ro_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (addr_i == SEL_PAD || addr_i == SEL_NONE)) |=>
      ($stable(dir_q) && $stable(lvl_q) && $stable(pen_q) && $stable(pol_q) && $stable(ien_q)));

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  pin_cfg_t cfg_i,
  input  logic     clr_i,
  input  logic     pad_i,
  output logic     pad_o,
  output logic     oe_o,
  output logic     pu_o,
  output logic     pd_o,
  output logic     flag_o,
  output logic     lvl_o
);
  logic sync_lvl;
  logic prev_q;
  logic flag_q;
  logic rise, fall, hit, set_now;

  gpio_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pad_i),
    .q_o  (sync_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_lvl;
  end

  always_comb begin
    rise    = sync_lvl & ~prev_q;
    fall    = ~sync_lvl & prev_q;
    hit     = cfg_i.pol ? rise : fall;
    set_now = hit & cfg_i.ien;
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_now) flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  // pad controls: pulls only for inputs, polarity picks the rail
  always_comb begin
    oe_o  = cfg_i.dir;
    pad_o = cfg_i.lvl;
    pu_o  = ~cfg_i.dir & cfg_i.pen & ~cfg_i.pol;
    pd_o  = ~cfg_i.dir & cfg_i.pen &  cfg_i.pol;
  end

  assign flag_o = flag_q;
  assign lvl_o  = sync_lvl;

  // R5: a flag only rises after a matching edge seen on the synchronized level
  a_r5_flag_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit));

  // R6: with the enable off a clear flag stays clear
  a_r6_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.ien && !flag_q) |=> !flag_q);

  // R8: a clear without a coincident set empties the flag
  a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_now) |=> !flag_q);

  // R8: a set always lands, even under a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> flag_q);

endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [NPINS-1:0]  reg_wdata_i,
  output logic [NPINS-1:0]  reg_rdata_o,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pull_up_o,
  output logic [NPINS-1:0]  pull_dn_o,
  output logic              irq_o
);
  pin_cfg_t [NPINS-1:0] cfg;
  logic     [NPINS-1:0] clr;
  logic     [NPINS-1:0] flags;
  logic     [NPINS-1:0] lvls;
  logic     [NPINS-1:0] ien_vec;
  logic     [NPINS-1:0] pending;

  gpio_cfg_regs #(.NPINS(NPINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .flag_i   (flags),
    .pad_lvl_i(lvls),
    .cfg_o    (cfg),
    .clr_o    (clr)
  );

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      gpio_pin_slice #(.SYNC_STAGES(SYNC_STAGES)) u_slice (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg_i (cfg[p]),
        .clr_i (clr[p]),
        .pad_i (pad_in_i[p]),
        .pad_o (pad_out_o[p]),
        .oe_o  (pad_oe_o[p]),
        .pu_o  (pull_up_o[p]),
        .pd_o  (pull_dn_o[p]),
        .flag_o(flags[p]),
        .lvl_o (lvls[p])
      );
      assign ien_vec[p] = cfg[p].ien;
    end
  endgenerate

  assign pending = flags & ien_vec;
  assign irq_o   = |pending;

  // R1: the first cycle out of reset is quiet on every output
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pad_oe_o == '0 && pull_up_o == '0 && pull_dn_o == '0 && !irq_o));

  // R4: an output pad never has a pull switched on
  a_r4_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe_o & (pull_up_o | pull_dn_o)) == '0));

  // R9: the request rises only when some flag newly pends
  a_r9_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (flags != '0));

endmodule

// File: tb/gpio_port8_bench.sv
module gpio_port8_bench;
  localparam int unsigned N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [2:0]   addr = 3'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic [N-1:0] ext = '0;
  logic [N-1:0] pad_in;
  logic [N-1:0] pad_out, pad_oe, pull_up, pull_dn;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // resolved pad: driven value when output, external level otherwise
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_port8 u_gpio_port8 (
    .clk(clk), .rst_n(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pull_up_o(pull_up),
    .pull_dn_o(pull_dn), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 register after reset", v, '0);
    end
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pulls", pull_up | pull_dn, '0);
    chk("R1 irq", {7'd0, irq}, '0);
  endtask

  task automatic t_direction();
    wr(3'd1, 8'h3C);
    wr(3'd0, 8'hA5);
    chk("R2 pad_oe", pad_oe, 8'hA5);
    chk("R2 pad_out", pad_out, 8'h3C);
    wr(3'd0, 8'h00);
    chk("R2 pad_oe cleared", pad_oe, 8'h00);
  endtask

  task automatic t_pulls();
    wr(3'd3, 8'h0F);
    wr(3'd2, 8'hFF);
    chk("R3 pull_up", pull_up, 8'hF0);
    chk("R3 pull_dn", pull_dn, 8'h0F);
    wr(3'd2, 8'h00);
    chk("R3 no pull when disabled", pull_up | pull_dn, 8'h00);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'hFF);
    chk("R4 pulls off for outputs", pull_up | pull_dn, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_edges();
    logic [N-1:0] v;
    wr(3'd3, 8'h01);
    wr(3'd4, 8'hFB);
    idle(4);
    ext = 8'h01;
    idle(2);
    rd(3'd5, v); chk("R5 flag not before third edge", v, 8'h00);
    idle(1);
    rd(3'd5, v); chk("R5 rising flag on third edge", v, 8'h01);
    ext = 8'h03; idle(4);
    rd(3'd5, v); chk("R5 rising ignored with polarity 0", v, 8'h01);
    ext = 8'h01; idle(4);
    rd(3'd5, v); chk("R5 falling flag with polarity 0", v, 8'h03);
    ext = 8'h05; idle(4);
    ext = 8'h01; idle(4);
    rd(3'd5, v); chk("R6 disabled pin sets no flag", v, 8'h03);
  endtask

  task automatic t_output_edge();
    logic [N-1:0] v;
    wr(3'd0, 8'h08);
    wr(3'd1, 8'h08); idle(4);
    rd(3'd5, v); chk("R7 rising ignored on output pin", v, 8'h03);
    wr(3'd1, 8'h00); idle(4);
    rd(3'd5, v); chk("R7 own falling edge flags output pin", v, 8'h0B);
  endtask

  task automatic t_irq_and_clear();
    logic [N-1:0] v;
    chk("R9 irq with pending flags", {7'd0, irq}, 8'h01);
    wr(3'd4, 8'h00);
    chk("R9 irq drops with enables off", {7'd0, irq}, 8'h00);
    rd(3'd5, v); chk("R9 flags kept with enables off", v, 8'h0B);
    wr(3'd4, 8'hFB);
    chk("R9 irq back with enables on", {7'd0, irq}, 8'h01);
    wr(3'd5, 8'h02);
    rd(3'd5, v); chk("R8 partial clear", v, 8'h09);
    wr(3'd5, 8'h09);
    rd(3'd5, v); chk("R8 full clear", v, 8'h00);
    chk("R9 irq idle", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [N-1:0] v;
    ext = 8'h00; idle(4);
    rd(3'd5, v); chk("R5 falling ignored with polarity 1", v, 8'h00);
    ext = 8'h01;
    idle(2);
    we = 1'b1; addr = 3'd5; wdata = 8'h01;
    @(negedge clk);
    we = 1'b0;
    rd(3'd5, v); chk("R8 set wins over same-cycle clear", v, 8'h01);
    wr(3'd5, 8'h01);
    rd(3'd5, v); chk("R8 later clear", v, 8'h00);
  endtask

  task automatic t_map();
    logic [N-1:0] v;
    ext = 8'hA1; idle(4);
    rd(3'd6, v); chk("R10 pad level read", v, 8'hA1);
    wr(3'd6, 8'hFF);
    rd(3'd6, v); chk("R10 pad level write ignored", v, 8'hA1);
    wr(3'd7, 8'hFF);
    rd(3'd7, v); chk("R10 unused address reads 0", v, 8'h00);
    rd(3'd0, v); chk("R10 direction unchanged", v, 8'h08);
    rd(3'd4, v); chk("R10 enable readback", v, 8'hFB);
    rd(3'd3, v); chk("R10 polarity readback", v, 8'h01);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_direction();
    t_pulls();
    t_edges();
    t_output_edge();
    t_irq_and_clear();
    t_set_wins();
    t_map();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule